// File: doc/BRIEF.md
# Interleaved Memory Line-Fill Controller

This block refills one cache line on a miss. The main memory behind it is split into four banks. Word addresses are spread across the banks from the low end, so the four words of one line sit in four different banks. The controller accepts a miss request that carries a word address. It sends the row part of that address to every bank in one shared send phase. The banks then look up their words in parallel. After that, the controller returns the four words to the cache one after another over a single 32-bit bus.

Each returned word has a strobe and its 2-bit offset within the line. A one-cycle completion pulse marks the last word. With the default phase lengths (send 4, access 24, return 4 per word), a line takes 44 cycles. A memory that is accessed word by word would take 128 cycles. The phase lengths are parameters. The bank contents are behavioural arrays that are preset at start-up from a fixed arithmetic pattern, so the cache side can check every word.

Top module: `ilv_fill_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `busy`, `fill_valid` and `done` are all 0.
- R2: A request is taken at a rising edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from that edge until the cycle of `done`, including that cycle, and is 0 in the cycle after it.
- R3: Word address `a` lives in bank `a[1:0]` at row `a[ADDR_W-1:2]`. Its preset content is the low 32 bits of `(a * 32'h9E3779B1) ^ 32'hC3A50000`. A beat with offset `k` carries the content of word address `{req_addr[ADDR_W-1:2], k}`.
- R4: `req_addr[1:0]` has no effect. A request with non-zero low bits returns the same four words as the aligned address of the same line.
- R5: Each request produces exactly four beats. `fill_valid` is high for one cycle per beat, and `fill_offset` is 0, 1, 2, 3 in that order.
- R6: Offset `k` appears in the cycle that starts `SEND_CYC + ACC_CYC + (k+1)*XFER_CYC - 1` rising edges after the accepting edge. With the defaults these are edges 31, 35, 39 and 43.
- R7: `done` is a single-cycle pulse that coincides with the offset-3 beat. The whole fill therefore takes `SEND_CYC + ACC_CYC + 4*XFER_CYC` cycles, which is 44 with the defaults, counting the cycle that starts at the accepting edge.
- R8: A `req_valid` seen while `busy` is 1 changes neither the data nor the timing of the fill in progress. It is not queued either: when it has dropped before the fill ends, no further beat follows `done`.
- R9: If `req_valid` stays high through a fill, the next request is taken at the edge one cycle after the `done` cycle. That edge is 45 edges after the previous accepting edge with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Word address of the missing line |
| busy | output | 1 | A fill is in progress |
| fill_valid | output | 1 | A returned word is on `fill_data` this cycle |
| fill_offset | output | 2 | Offset of the returned word within the line |
| fill_data | output | 32 | Returned word |
| done | output | 1 | Last word of the line is being returned |

## Verification
A wrong phase counter or phase encoding would move every beat of the line. The beat cycle is compared exactly against the 31/35/39/43 pattern, so such a fault shows on the first beat of the first fill, 31 cycles after acceptance. A wrong row latch or bank selection corrupts the data of a specific offset. The preset pattern differs for every word address, so a swapped bank or a shifted row index shows as a data mismatch on the first affected beat. A state machine that re-arms while busy, or that queues a request, shows as a stray beat or a missing `busy` release within one cycle of `done`.

// File: rtl/ilv_fill_pkg.sv
package ilv_fill_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SEND   = 2'd1,
    PH_ACCESS = 2'd2,
    PH_RETURN = 2'd3
  } fill_phase_e;

  // Preset content of one memory word, indexed by its global word address.
  function automatic logic [WORD_W-1:0] preset_word(input int unsigned waddr);
    logic [31:0] prod;
    prod = 32'(waddr) * 32'h9E3779B1;
    return prod ^ 32'hC3A50000;
  endfunction

  // Cycles a full line occupies, counted from the accepting edge.
  function automatic int unsigned line_cycles(input int unsigned send_c,
                                              input int unsigned acc_c,
                                              input int unsigned xfer_c,
                                              input int unsigned nwords);
    return send_c + acc_c + nwords * xfer_c;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ilv_phase_seq.sv
module ilv_phase_seq
  import ilv_fill_pkg::*;
#(
  parameter int SEND_CYC = 4,
  parameter int ACC_CYC  = 24,
  parameter int XFER_CYC = 4,
  parameter int NBANK    = 4,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int CNT_W   = $clog2(max3(SEND_CYC, ACC_CYC, XFER_CYC) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output fill_phase_e       phase,
  output logic [BANK_W-1:0] beat_idx,
  output logic              ev_accept,
  output logic              ev_sent,
  output logic              ev_accessed,
  output logic              ev_beat,
  output logic              ev_last
);

  fill_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BANK_W-1:0] widx_q, widx_d;

  assign ev_accept   = (phase_q == PH_IDLE) && req_valid;
  assign ev_sent     = (phase_q == PH_SEND) && (cnt_q == CNT_W'(SEND_CYC - 1));
  assign ev_accessed = (phase_q == PH_ACCESS) && (cnt_q == CNT_W'(ACC_CYC - 1));
  assign ev_beat     = (phase_q == PH_RETURN) && (cnt_q == CNT_W'(XFER_CYC - 1));
  assign ev_last     = ev_beat && (widx_q == BANK_W'(NBANK - 1));

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CNT_W'(1);
    widx_d  = widx_q;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (ev_accept) phase_d = PH_SEND;
      end
      PH_SEND: begin
        if (ev_sent) begin
          phase_d = PH_ACCESS;
          cnt_d   = '0;
        end
      end
      PH_ACCESS: begin
        if (ev_accessed) begin
          phase_d = PH_RETURN;
          cnt_d   = '0;
          widx_d  = '0;
        end
      end
      PH_RETURN: begin
        if (ev_beat) begin
          cnt_d  = '0;
          widx_d = widx_q + BANK_W'(1);
          if (ev_last) phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      widx_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      widx_q  <= widx_d;
    end
  end

  assign phase    = phase_q;
  assign beat_idx = widx_q;

endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_fill_pkg::*;
#(
  parameter int ROWS    = 64,
  parameter int NBANK   = 4,
  parameter int BANK_ID = 0,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  row_in,
  input  logic              row_load,
  input  logic              read_en,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] store [ROWS];
  logic [ROW_W-1:0]  row_q;

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      store[r] = preset_word(int'(r * NBANK + BANK_ID));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      rd_data <= '0;
    end else begin
      if (row_load) row_q   <= row_in;
      if (read_en)  rd_data <= store[row_q];
    end
  end

endmodule

// File: rtl/ilv_return_mux.sv
module ilv_return_mux
  import ilv_fill_pkg::*;
#(
  parameter int NBANK   = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic [NBANK*WORD_W-1:0] words_flat,
  input  logic [BANK_W-1:0]       sel,
  output logic [WORD_W-1:0]       word_out
);

  assign word_out = words_flat[sel * WORD_W +: WORD_W];

endmodule

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl
  import ilv_fill_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NBANK    = 4,
  parameter int SEND_CYC = 4,
  parameter int ACC_CYC  = 24,
  parameter int XFER_CYC = 4,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int ROW_W   = ADDR_W - BANK_W,
  localparam int ROWS    = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              fill_valid,
  output logic [BANK_W-1:0] fill_offset,
  output logic [WORD_W-1:0] fill_data,
  output logic              done
);

  fill_phase_e         phase;
  logic [BANK_W-1:0]   beat_idx;
  logic                ev_accept, ev_sent, ev_accessed, ev_beat, ev_last;
  logic [ROW_W-1:0]    row_bcast;
  logic [NBANK*WORD_W-1:0] bank_words;

  ilv_phase_seq #(
    .SEND_CYC(SEND_CYC), .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC), .NBANK(NBANK)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .phase(phase), .beat_idx(beat_idx),
    .ev_accept(ev_accept), .ev_sent(ev_sent), .ev_accessed(ev_accessed),
    .ev_beat(ev_beat), .ev_last(ev_last)
  );

  // Row part of the line address, captured once and broadcast to all banks.
  always_ff @(posedge clk) begin
    if (!rst_n) row_bcast <= '0;
    else if (ev_accept) row_bcast <= ROW_W'(req_addr >> BANK_W);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ilv_bank #(.ROWS(ROWS), .NBANK(NBANK), .BANK_ID(b)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .row_in(row_bcast), .row_load(ev_sent), .read_en(ev_accessed),
      .rd_data(bank_words[b*WORD_W +: WORD_W])
    );
  end

  ilv_return_mux #(.NBANK(NBANK)) u_mux (
    .words_flat(bank_words), .sel(beat_idx), .word_out(fill_data)
  );

  assign busy        = (phase != PH_IDLE);
  assign fill_valid  = ev_beat;
  assign fill_offset = beat_idx;
  assign done        = ev_last;

endmodule

// File: rtl/ilv_fill_chk.sv
module ilv_fill_chk
  import ilv_fill_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int SEND_CYC = 4,
  parameter int ACC_CYC  = 24,
  parameter int XFER_CYC = 4,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int TOTAL   = int'(line_cycles(SEND_CYC, ACC_CYC, XFER_CYC, NBANK))
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              fill_valid,
  input logic [BANK_W-1:0] fill_offset,
  input logic              done,
  input logic              ev_accept
);

  int unsigned since_acc;
  int unsigned beats_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_acc  <= 0;
      beats_seen <= 0;
    end else if (ev_accept) begin
      since_acc  <= 0;
      beats_seen <= 0;
    end else begin
      if (busy)       since_acc  <= since_acc + 1;
      if (fill_valid) beats_seen <= beats_seen + 1;
    end
  end

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fill_valid && !done));

  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (int'(fill_offset) == int'(beats_seen)));

  assert_beat_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (since_acc == SEND_CYC + ACC_CYC + (beats_seen + 1) * XFER_CYC - 1));

  assert_done_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fill_valid && fill_offset == BANK_W'(NBANK - 1) && since_acc == TOTAL - 1));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !busy);

  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind ilv_fill_ctrl ilv_fill_chk #(
  .NBANK(NBANK), .SEND_CYC(SEND_CYC), .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC)
) u_fill_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .fill_valid(fill_valid), .fill_offset(fill_offset), .done(done),
  .ev_accept(ev_accept)
);

// File: tb/test_ilv_fill_ctrl.sv
`timescale 1ns/1ps
module test_ilv_fill_ctrl;

  localparam int AW = 8;
  localparam int SC = 4;
  localparam int AC = 24;
  localparam int XC = 4;
  localparam int FIRST_BEAT = SC + AC + XC - 1;   // 31
  localparam int LINE = SC + AC + 4 * XC;         // 44

  typedef struct {
    int          cyc;
    logic [1:0]  off;
    logic [31:0] data;
    bit          last;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          busy, fill_valid, done;
  logic [1:0]    fill_offset;
  logic [31:0]   fill_data;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_fill_ctrl #(.ADDR_W(AW), .NBANK(4), .SEND_CYC(SC), .ACC_CYC(AC), .XFER_CYC(XC))
    i_ilv_fill_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .busy(busy), .fill_valid(fill_valid), .fill_offset(fill_offset),
      .fill_data(fill_data), .done(done)
    );

  // Bench model of the preset memory: hashed word address.
  function automatic logic [31:0] model_word(input int a);
    logic [63:0] wide;
    wide = 64'(a) * 64'h9E3779B1;
    return wide[31:0] ^ 32'hC3A50000;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_line(input int addr, input int acc);
    int base;
    base = addr & ~3;
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.cyc  = acc + FIRST_BEAT + k * XC;
      e.off  = 2'(k);
      e.data = model_word(base + k);
      e.last = (k == 3);
      sb.push_back(e);
    end
  endtask

  task automatic issue(input int addr, output int acc);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(addr);
    @(posedge clk);
    #1;
    acc = cyc;
    push_line(addr, acc);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R2 busy released after done", busy, 0);
  endtask

  // Monitor: every beat is popped from the scoreboard and compared.
  always @(negedge clk) begin
    if (rst_n && (fill_valid || done)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected beat", fill_offset, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(fill_valid == 1'b1, "R7 done without beat", fill_valid, 1);
        check(cyc == e.cyc, "R6 beat cycle", cyc, e.cyc);
        check(fill_offset == e.off, "R5 beat offset", fill_offset, e.off);
        check(fill_data == e.data, "R3 beat data", fill_data, e.data);
        check(done == e.last, "R7 done on last beat", done, e.last);
      end
    end
  end

  initial begin : watchdog
    wait (cyc == 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int acc, acc2;
    repeat (3) @(negedge clk);
    check(!busy && !fill_valid && !done, "R1 reset outputs", {busy, fill_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !fill_valid && !done, "R1 after release", {busy, fill_valid, done}, 0);

    // R3/R5/R6/R7 on several lines, including the first and the last.
    issue(0, acc);    drain();
    issue(4, acc);    drain();
    issue(60, acc);   drain();
    issue(252, acc);  drain();

    // R4: low bits set, same line as 80.
    issue(83, acc);   drain();
    issue(81, acc);   drain();

    // R8: a request pulse while busy leaves the fill alone and is not queued.
    issue(128, acc);
    repeat (8) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 8'd200;
    @(negedge clk);
    check(busy == 1'b1, "R8 still busy", busy, 1);
    req_valid = 1'b0;
    drain();
    repeat (60) @(negedge clk);
    check(busy == 1'b0, "R8 no queued fill", busy, 0);

    // R9: request held high through a fill, second line taken one cycle after done.
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 8'd20;
    @(posedge clk);
    #1;
    acc = cyc;
    push_line(20, acc);
    @(negedge clk);
    req_addr = 8'd100;
    while (cyc < acc + LINE) @(negedge clk);
    check(busy == 1'b0, "R9 idle gap cycle", busy, 0);
    @(posedge clk);
    #1;
    acc2 = cyc;
    push_line(100, acc2);
    @(negedge clk);
    check(busy == 1'b1, "R9 re-accept", busy, 1);
    check(acc2 - acc == LINE + 1, "R9 accept spacing", acc2 - acc, LINE + 1);
    req_valid = 1'b0;
    drain();
    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R5 all beats seen", sb.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule